// File: doc/BRIEF.md
# Multi-Scale Input Glitch Filter

This block cleans up one asynchronous input line before it reaches the pin-status and interrupt logic. The raw level passes through a synchronizer into the system clock domain. A filter stage then decides when the output level may follow it. Time is measured in units built from a slow real-time tick. That tick reaches the block as a one-cycle enable pulse in the system clock domain. A two-bit scale select picks how many ticks make one unit. A four-bit count sets how many units the input must stay stable before a change is accepted.

Four filter modes are available. Bypass forwards the synchronized level with no filtering. Symmetric mode rejects short pulses in both directions, which suits a line that feeds edge detection. The two asymmetric modes each let one direction through at once and hold back only the other direction. They are used for level-sensitive lines, so that a brief assertion of the active level is never lost. Any configuration write restarts the timing. The caller must present the configuration fields already in the system clock domain.

Top module: `pin_deglitch`

## Requirements
- R1: After reset `pin_filt` is 0 and the stored mode is bypass (mode code 0).
- R2: In bypass mode (code 0), `pin_filt` follows `pin_raw` three clock edges after the input changes: two synchronizer stages and the output register.
- R3: The scale bits `{cfg_large, cfg_unit}` choose the ticks per unit: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R4: In symmetric mode (code 1), a change of the synchronized input reaches `pin_filt` on the tick that completes `cfg_count` whole units of uninterrupted difference, and not one tick earlier.
- R5: A count of 0 in any filtering mode behaves as a count of 1, so it gives a one-unit filter.
- R6: If the synchronized input returns to the output level before the timeout ends, the accumulated time is discarded, so a later difference must again last the full timeout.
- R7: In mode code 2, a falling input passes to `pin_filt` one edge after synchronization, while a rising input must meet the full timeout.
- R8: Mode code 3 mirrors R7: a rising input passes at once, and a falling input must meet the full timeout.
- R9: A write (`cfg_we` high) stores all configuration fields, clears the accumulated time, and holds `pin_filt` for that cycle.
- R10: In any filtering mode, time advances only on cycles where `rtc_tick` is high. Without ticks, `pin_filt` never changes through the timed path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rtc_tick | input | 1 | One-cycle pulse per real-time tick |
| pin_raw | input | 1 | Unsynchronized input level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_count | input | 4 | Timeout in units |
| cfg_unit | input | 1 | Scale select, low bit |
| cfg_large | input | 1 | Scale select, high bit |
| cfg_mode | input | 2 | 0 bypass, 1 symmetric, 2 pass falling, 3 pass rising |
| pin_filt | output | 1 | Filtered level |

## Verification
Two situations are hard to reach from the ports. One is a difference that ends one unit short of the timeout. The other is a timeout that spans the largest scale. The bench reaches both by driving `rtc_tick` itself, one pulse at a time. This lets it stop exactly one tick before acceptance and check the output there, then add the final tick. For restart behaviour, it interrupts a difference at a known tick count, either by flipping the input back or by rewriting the configuration. It then shows that a full count of ticks is needed once more.

// File: rtl/pin_deglitch.sv
module pin_deglitch #(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TICKS_S0    = 2,
  parameter int TICKS_S1    = 8,
  parameter int TICKS_S2    = 512,
  parameter int TICKS_S3    = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rtc_tick,
  input  logic             pin_raw,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             cfg_unit,
  input  logic             cfg_large,
  input  logic [1:0]       cfg_mode,
  output logic             pin_filt
);
  localparam int PRE_W = $clog2(TICKS_S3);
  localparam logic [1:0] M_BYPASS = 2'd0;
  localparam logic [1:0] M_BOTH   = 2'd1;
  localparam logic [1:0] M_PASSLO = 2'd2;
  localparam logic [1:0] M_PASSHI = 2'd3;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q, units_q, target_m1;
  logic [1:0]             scale_q, mode_q;
  logic [PRE_W-1:0]       pre_q, pre_last;
  logic                   filt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};

  wire pin_s = sync_q[SYNC_STAGES-1];

  always_comb
    case (scale_q)
      2'd0:    pre_last = PRE_W'(TICKS_S0 - 1);
      2'd1:    pre_last = PRE_W'(TICKS_S1 - 1);
      2'd2:    pre_last = PRE_W'(TICKS_S2 - 1);
      default: pre_last = PRE_W'(TICKS_S3 - 1);
    endcase

  assign target_m1 = (cnt_q == '0) ? '0 : cnt_q - 1'b1;

  wire differ   = pin_s != filt_q;
  wire fast     = (mode_q == M_PASSLO && !pin_s) || (mode_q == M_PASSHI && pin_s);
  wire unit_end = rtc_tick && pre_q == pre_last;
  wire accept   = unit_end && units_q == target_m1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      scale_q <= '0;
      mode_q  <= M_BYPASS;
      pre_q   <= '0;
      units_q <= '0;
      filt_q  <= 1'b0;
    end else if (cfg_we) begin
      cnt_q   <= cfg_count;
      scale_q <= {cfg_large, cfg_unit};
      mode_q  <= cfg_mode;
      pre_q   <= '0;
      units_q <= '0;
    end else if (mode_q == M_BYPASS || !differ || fast) begin
      filt_q  <= pin_s;
      pre_q   <= '0;
      units_q <= '0;
    end else if (rtc_tick) begin
      if (!unit_end) begin
        pre_q <= pre_q + 1'b1;
      end else begin
        pre_q <= '0;
        if (accept) begin
          filt_q  <= pin_s;
          units_q <= '0;
        end else begin
          units_q <= units_q + 1'b1;
        end
      end
    end

  assign pin_filt = filt_q;
endmodule

module pin_deglitch_chk #(parameter int CNT_W = 4) (
  input logic             clk,
  input logic             rst_n,
  input logic             rtc_tick,
  input logic             cfg_we,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] units_q,
  input logic             pin_s,
  input logic             pin_filt
);
  a_r1_reset_low: assert property (@(posedge clk) $rose(rst_n) |-> !pin_filt);

  a_r2_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && $past(mode_q) == 2'd0 && !$past(cfg_we)) |-> pin_filt == $past(pin_s));

  a_r9_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_we) |-> $stable(pin_filt));

  a_r10_both_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == 2'd1 && pin_filt != $past(pin_filt)) |-> $past(rtc_tick));

  a_r7_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == 2'd2 && $rose(pin_filt)) |-> $past(rtc_tick));

  a_r8_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == 2'd3 && $fell(pin_filt)) |-> $past(rtc_tick));

  a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_s) == $past(pin_filt) && !$past(cfg_we)) |-> units_q == '0);
endmodule

bind pin_deglitch pin_deglitch_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .cfg_we(cfg_we),
  .mode_q(mode_q), .units_q(units_q), .pin_s(pin_s), .pin_filt(pin_filt)
);

// File: tb/sim_pin_deglitch.sv
module sim_pin_deglitch;
  logic clk = 0, rst_n = 0, rtc_tick = 0, pin_raw = 0, cfg_we = 0;
  logic [3:0] cfg_count = 0;
  logic cfg_unit = 0, cfg_large = 0;
  logic [1:0] cfg_mode = 0;
  logic pin_filt;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  pin_deglitch u0 (.clk, .rst_n, .rtc_tick, .pin_raw, .cfg_we, .cfg_count,
                   .cfg_unit, .cfg_large, .cfg_mode, .pin_filt);

  // {mode[25:24], large[23], unit[22], count[21:18], start[17], target[16], ticks[15:0]}
  localparam int NV = 11;
  localparam logic [25:0] VEC [NV] = '{
    {2'd1, 1'b0, 1'b0, 4'd3,  1'b0, 1'b1, 16'd6},
    {2'd1, 1'b0, 1'b1, 4'd2,  1'b1, 1'b0, 16'd16},
    {2'd1, 1'b1, 1'b0, 4'd1,  1'b0, 1'b1, 16'd512},
    {2'd1, 1'b1, 1'b1, 4'd1,  1'b1, 1'b0, 16'd2048},
    {2'd1, 1'b0, 1'b0, 4'd0,  1'b0, 1'b1, 16'd2},
    {2'd1, 1'b0, 1'b0, 4'd15, 1'b1, 1'b0, 16'd30},
    {2'd2, 1'b0, 1'b0, 4'd4,  1'b1, 1'b0, 16'd0},
    {2'd2, 1'b0, 1'b0, 4'd4,  1'b0, 1'b1, 16'd8},
    {2'd3, 1'b0, 1'b0, 4'd4,  1'b0, 1'b1, 16'd0},
    {2'd3, 1'b0, 1'b0, 4'd4,  1'b1, 1'b0, 16'd8},
    {2'd0, 1'b0, 1'b0, 4'd5,  1'b0, 1'b1, 16'd0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pin_filt=%b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      rtc_tick = 1; @(negedge clk);
      rtc_tick = 0; @(negedge clk);
    end
  endtask

  task automatic write_cfg(input logic [1:0] m, input logic lg, input logic un, input logic [3:0] c);
    cfg_mode = m; cfg_large = lg; cfg_unit = un; cfg_count = c; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic preset(input logic lvl);
    write_cfg(2'd0, 1'b0, 1'b0, 4'd0);
    pin_raw = lvl;
    cyc(4);
  endtask

  initial begin : watchdog
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: pin_filt=%b expected completion", pin_filt);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 reset", pin_filt, 1'b0);
    rst_n = 1;
    cyc(1);
    pin_raw = 1; cyc(2);
    chk("R2 bypass not before third edge", pin_filt, 1'b0);
    cyc(1);
    chk("R2 bypass third edge / R1 default mode", pin_filt, 1'b1);

    for (int v = 0; v < NV; v++) begin
      logic [25:0] e;
      e = VEC[v];
      preset(e[17]);
      write_cfg(e[25:24], e[23], e[22], e[21:18]);
      pin_raw = e[16];
      if (e[15:0] == 0) begin
        cyc(2);
        chk("R7/R8/R2 before pass", pin_filt, e[17]);
        cyc(1);
        chk("R7/R8/R2 immediate pass", pin_filt, e[16]);
      end else begin
        cyc(3);
        ticks(int'(e[15:0]) - 1);
        chk("R3/R4/R5/R7/R8 one tick short", pin_filt, e[17]);
        ticks(1);
        chk("R3/R4/R5/R7/R8 accepted", pin_filt, e[16]);
      end
    end

    // R6: interrupted difference restarts; symmetric, 2 units of 2 ticks
    preset(1'b0);
    write_cfg(2'd1, 1'b0, 1'b0, 4'd2);
    pin_raw = 1; cyc(3); ticks(3);
    pin_raw = 0; cyc(3);
    chk("R6 glitch rejected", pin_filt, 1'b0);
    pin_raw = 1; cyc(3); ticks(3);
    chk("R6 restart needs full time", pin_filt, 1'b0);
    ticks(1);
    chk("R6 accepted after full time", pin_filt, 1'b1);

    // R9: rewrite restarts timing
    pin_raw = 0; cyc(3); ticks(3);
    write_cfg(2'd1, 1'b0, 1'b0, 4'd2);
    ticks(3);
    chk("R9 write restarts count", pin_filt, 1'b1);
    ticks(1);
    chk("R9 accepted after restart", pin_filt, 1'b0);

    // R10: no ticks, no change
    pin_raw = 1; cyc(200);
    chk("R10 no tick no change", pin_filt, 1'b0);
    ticks(4);
    chk("R10 ticks then change", pin_filt, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule